// File: doc/BRIEF.md
# Memory-Mapped Interrupt Request Aggregator

This block collects thirty-two interrupt request wires from peripherals and merges them into one interrupt line toward the processor. Each wire first crosses into the bus clock domain through a two-stage synchronizer. It is then inverted or passed through according to its own polarity bit. Finally it either follows the live input level or latches a pending flag on the active transition. The pending set is gated by an enable mask, and the gated set is OR-reduced into the processor interrupt.

Software reaches the block through a single-cycle register port. It reads the pending summary, which holds every pending line at once with bit n for line n, and services the lines lowest bit first. It programs the enable, sensitivity and polarity words. It dismisses an edge-latched line by writing a word with that line's bit set into the clear register and then writing zero. Lines 20 to 30 have no source and are forced quiet. Writing a fixed key word to the restart register produces a one-cycle system reset request.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable word reads 0x00000000, the sensitivity word reads 0x00000000 (all lines level-sensitive), the polarity word reads 0x80000000, and the interrupt output and the reset request are low.
- R2: In level mode (sensitivity bit 0), summary bit n follows the polarity-adjusted line n after the two-stage synchronizer, and it drops when the input returns to its inactive state.
- R3: Polarity bit n = 1 makes line n active-high and 0 makes it active-low; a change of the polarity word takes effect on the summary without any input change.
- R4: In edge mode (sensitivity bit 1), an inactive-to-active transition sets pending bit n, and the bit stays set after the input goes back to inactive.
- R5: While clear-register bit n is 1, edge-mode pending bit n is held at 0; after the clear register is written back to zero the bit stays clear until the next active transition. Level-mode lines keep reporting their live input whatever the clear register holds.
- R6: Summary bits 20 to 30 always read 0 and never raise the interrupt output, whatever their inputs, polarity or enable bits.
- R7: The interrupt output is high, one cycle after the summary changes, exactly when some summary bit is set together with its enable bit; an enable bit of 0 blocks its line.
- R8: A write of 0x0000DEAD to the restart register (byte offset 0x14) raises the reset request for exactly one cycle; any other value written there leaves it low.
- R9: The byte offsets are: summary 0x00, enable 0x04, sensitivity 0x08, polarity 0x0C, clear 0x10, restart 0x14. Read data appears in the cycle after the read strobe, and reads of any other address (including ones that are not word-aligned) return 0.
- R10: Several lines that are active together all appear in one summary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines_i | input | 32 | Asynchronous interrupt request wires, one per line |
| bus_addr_i | input | 5 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| cpu_irq_o | output | 1 | Merged interrupt to the processor |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The summary is read with all lines idle, with all low-active lines asserted at once, and with a single line asserted. This separates the per-line mapping and the polarity inversion from a plain copy of the input. Edge lines are pulsed and released, then cleared, next to a level line that is held active while the clear register holds its bit; this shows latched pending apart from live level and shows the clear register's effect on each. All lines are driven active under all-high polarity with only the unused span enabled, which shows that the reserved lines cannot raise the interrupt. Key and non-key values are written to the restart register to tell the request pulse apart from a plain write decode.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and register decoding for the interrupt aggregator.
// Assumes byte addressing with word-aligned 32-bit registers.
package irq_agg_pkg;

    localparam logic [31:0] RESTART_KEY = 32'h0000_DEAD;

    // Register selector produced from a byte address.
    typedef enum logic [2:0] {
        SEL_SUMMARY,
        SEL_ENABLE,
        SEL_SENSE,
        SEL_POLARITY,
        SEL_CLEAR,
        SEL_RESTART,
        SEL_NONE
    } reg_sel_e;

    // Map a byte address onto a register; misaligned or unknown gives SEL_NONE.
    function automatic reg_sel_e decode_addr(input logic [4:0] addr);
        reg_sel_e sel;
        if (addr[1:0] != 2'b00) begin
            sel = SEL_NONE;
        end else begin
            case (addr[4:2])
                3'd0:    sel = SEL_SUMMARY;
                3'd1:    sel = SEL_ENABLE;
                3'd2:    sel = SEL_SENSE;
                3'd3:    sel = SEL_POLARITY;
                3'd4:    sel = SEL_CLEAR;
                3'd5:    sel = SEL_RESTART;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous request wires.
// Assumes each bit is independent (no bus coherency is needed across bits).
// The reset value is chosen by the parent so that lines read as idle after reset.
module irq_sync #(
    parameter int unsigned            WIDTH   = 32,
    parameter int unsigned            STAGES  = 2,
    parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture flop, may go metastable.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                // Purpose: further settling stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_capture.sv
// Module: per-line polarity adjustment and edge/level capture.
// Assumes synchronized inputs. Produces the pending summary with reserved
// lines forced to zero. Edge-mode lines latch on the inactive-to-active
// transition and stay set until the clear word holds their bit.
module irq_capture #(
    parameter int unsigned      WIDTH = 32,
    parameter logic [WIDTH-1:0] RSVD  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] edge_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] summary_o
);

    logic [WIDTH-1:0] active;
    logic [WIDTH-1:0] active_prev_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] rise;

    // Purpose: active-high view of each line (pol 1 = high active).
    assign active = ~(sync_i ^ pol_i);
    assign rise   = active & ~active_prev_q;

    // Purpose: remember the previous active view for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_prev_q <= '0;
        else        active_prev_q <= active;
    end

    generate
        for (genvar n = 0; n < WIDTH; n++) begin : g_line
            if (RSVD[n]) begin : g_unused
                assign pend_q[n]    = 1'b0;
                assign summary_o[n] = 1'b0;
            end else begin : g_used
                // Purpose: edge latch; clear has priority, level mode keeps it empty.
                always_ff @(posedge clk) begin
                    if (!rst_n)                  pend_q[n] <= 1'b0;
                    else if (!edge_i[n])         pend_q[n] <= 1'b0;
                    else if (clr_i[n])           pend_q[n] <= 1'b0;
                    else if (rise[n])            pend_q[n] <= 1'b1;
                end
                // Purpose: select latched or live view per line.
                assign summary_o[n] = edge_i[n] ? pend_q[n] : active[n];
            end
        end
    endgenerate

    // R5: a held clear bit leaves no pending bit behind on the next cycle.
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_i)) == '0));

    // R4: an edge latch survives unless cleared or switched to level mode.
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_i) & $past(edge_i)) & ~pend_q) == '0));

endmodule

// File: rtl/irq_regfile.sv
// Module: software-visible register file with a single-cycle bus port.
// Assumes one access strobe per cycle; read data is registered.
// Also produces the one-cycle restart request on the key write.
module irq_regfile
    import irq_agg_pkg::*;
#(
    parameter int unsigned      WIDTH   = 32,
    parameter int unsigned      AW      = 5,
    parameter logic [WIDTH-1:0] POL_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    input  logic [WIDTH-1:0] summary_i,
    output logic [WIDTH-1:0] enable_o,
    output logic [WIDTH-1:0] edge_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] clr_o,
    output logic             restart_o
);

    reg_sel_e sel;

    assign sel = decode_addr(addr_i);

    // Purpose: software writes to the configuration and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
            edge_o   <= '0;
            pol_o    <= POL_RST;
            clr_o    <= '0;
        end else if (wr_i) begin
            case (sel)
                SEL_ENABLE:   enable_o <= wdata_i;
                SEL_SENSE:    edge_o   <= wdata_i;
                SEL_POLARITY: pol_o    <= wdata_i;
                SEL_CLEAR:    clr_o    <= wdata_i;
                default:      ;
            endcase
        end
    end

    // Purpose: one-cycle restart request on the key value.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_o <= 1'b0;
        else        restart_o <= wr_i && (sel == SEL_RESTART) &&
                                 (wdata_i == WIDTH'(RESTART_KEY));
    end

    // Purpose: registered read mux; unmapped addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            case (sel)
                SEL_SUMMARY:  rdata_o <= summary_i;
                SEL_ENABLE:   rdata_o <= enable_o;
                SEL_SENSE:    rdata_o <= edge_o;
                SEL_POLARITY: rdata_o <= pol_o;
                SEL_CLEAR:    rdata_o <= clr_o;
                default:      rdata_o <= '0;
            endcase
        end else begin
            rdata_o <= '0;
        end
    end

    // R8: a request pulse is only ever caused by a key write to the restart register.
    a_r8_key_only: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(wr_i && (sel == SEL_RESTART) && (wdata_i == WIDTH'(RESTART_KEY))));

    // R9: unmapped reads return zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_i && (sel == SEL_NONE)) |-> (rdata_o == '0));

endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator.
// Chains synchronizer -> capture -> register file and merges the enabled
// pending lines into one registered processor interrupt.
// Assumes a single clock domain for the bus; request wires may be asynchronous.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RSVD_LO     = 20,
    parameter int unsigned RSVD_HI     = 30,
    parameter int unsigned CASCADE_BIT = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 cpu_irq_o,
    output logic                 sys_rst_req_o
);

    // Build a mask with ones from lo to hi inclusive.
    function automatic logic [NUM_LINES-1:0] span_mask(input int unsigned lo,
                                                       input int unsigned hi);
        logic [NUM_LINES-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NUM_LINES; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NUM_LINES-1:0] RSVD_MASK = span_mask(RSVD_LO, RSVD_HI);
    localparam logic [NUM_LINES-1:0] POL_INIT  = NUM_LINES'(1) << CASCADE_BIT;
    localparam logic [NUM_LINES-1:0] SYNC_IDLE = ~POL_INIT;

    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] summary;
    logic [NUM_LINES-1:0] enable_w;
    logic [NUM_LINES-1:0] edge_w;
    logic [NUM_LINES-1:0] pol_w;
    logic [NUM_LINES-1:0] clr_w;

    irq_sync #(
        .WIDTH   (NUM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines_i),
        .sync_o  (sync_lines)
    );

    irq_capture #(
        .WIDTH (NUM_LINES),
        .RSVD  (RSVD_MASK)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_lines),
        .pol_i     (pol_w),
        .edge_i    (edge_w),
        .clr_i     (clr_w),
        .summary_o (summary)
    );

    irq_regfile #(
        .WIDTH   (NUM_LINES),
        .AW      (ADDR_W),
        .POL_RST (POL_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr_i),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .wdata_i   (bus_wdata_i),
        .rdata_o   (bus_rdata_o),
        .summary_i (summary),
        .enable_o  (enable_w),
        .edge_o    (edge_w),
        .pol_o     (pol_w),
        .clr_o     (clr_w),
        .restart_o (sys_rst_req_o)
    );

    // Purpose: registered OR of enabled pending lines toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq_o <= 1'b0;
        else        cpu_irq_o <= |(summary & enable_w);
    end

    // R7: with every enable bit clear the processor interrupt stays low.
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w == '0) |=> !cpu_irq_o);

    // R6: a summary read never shows a reserved line.
    a_r6_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd_i && (bus_addr_i == ADDR_W'(0))) |-> ((bus_rdata_o & RSVD_MASK) == '0));

endmodule

// File: tb/irq_aggregator_bench.sv
// Directed bench for the interrupt aggregator: one task per scenario.
module irq_aggregator_bench;

    localparam logic [4:0] A_SUM = 5'h00, A_EN = 5'h04, A_EDGE = 5'h08,
                           A_POL = 5'h0C, A_CLR = 5'h10, A_RST = 5'h14;
    localparam logic [31:0] IDLE = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = IDLE;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rreq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_lines_i   (lines),
        .bus_addr_i    (addr),
        .bus_wr_i      (wr),
        .bus_rd_i      (rd),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .cpu_irq_o     (irq),
        .sys_rst_req_o (rreq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        d = rdata; rd = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rstreq", {31'd0, rreq}, 32'd0);
        bus_read(A_EN, d);   check("R1 enable", d, 32'h0);
        bus_read(A_EDGE, d); check("R1 sense", d, 32'h0);
        bus_read(A_POL, d);  check("R1 polarity", d, 32'h8000_0000);
        bus_read(A_SUM, d);  check("R1 summary idle", d, 32'h0);
    endtask

    task automatic t_level_polarity();
        logic [31:0] d;
        lines = 32'h0;                  // every low-active line asserted
        wait_cyc(4);
        bus_read(A_SUM, d); check("R2 R10 all low-active", d, 32'h000F_FFFF);
        lines = IDLE & ~32'h0000_0400; // only line 10
        wait_cyc(4);
        bus_read(A_SUM, d); check("R2 single line", d, 32'h0000_0400);
        lines = IDLE;
        wait_cyc(4);
        bus_read(A_SUM, d); check("R2 level drops", d, 32'h0);
        bus_write(A_POL, 32'h8000_0004); // line 2 now high-active, input high
        bus_read(A_SUM, d); check("R3 polarity flip", d, 32'h0000_0004);
        lines = 32'hFFFF_FFFF;         // cascade line high as well
        wait_cyc(4);
        bus_read(A_SUM, d); check("R3 R10 high-active pair", d, 32'h8000_0004);
        lines = IDLE;
        bus_write(A_POL, 32'h8000_0000);
        wait_cyc(4);
        bus_read(A_SUM, d); check("R3 restored", d, 32'h0);
    endtask

    task automatic t_edge_clear();
        logic [31:0] d;
        bus_write(A_EDGE, 32'h0000_0008);
        lines = IDLE & ~32'h8;
        wait_cyc(4);
        bus_read(A_SUM, d); check("R4 edge set", d, 32'h8);
        lines = IDLE;
        wait_cyc(4);
        bus_read(A_SUM, d); check("R4 edge held", d, 32'h8);
        bus_write(A_CLR, 32'h8);
        bus_read(A_SUM, d); check("R5 clear held", d, 32'h0);
        bus_write(A_CLR, 32'h0);
        bus_read(A_SUM, d); check("R5 after zero", d, 32'h0);
        lines = IDLE & ~32'h20;        // level line 5 active
        wait_cyc(4);
        bus_write(A_CLR, 32'h20);
        bus_read(A_SUM, d); check("R5 level ignores clear", d, 32'h20);
        bus_write(A_CLR, 32'h0);
        lines = IDLE;
        bus_write(A_EDGE, 32'h0);
        wait_cyc(4);
    endtask

    task automatic t_mask_irq();
        lines = IDLE & ~32'h80;
        wait_cyc(4);
        check("R7 masked off", {31'd0, irq}, 32'd0);
        bus_write(A_EN, 32'h80);
        wait_cyc(2);
        check("R7 enabled", {31'd0, irq}, 32'd1);
        lines = IDLE & ~32'h100;      // line 8 active but not enabled
        wait_cyc(5);
        check("R7 other line blocked", {31'd0, irq}, 32'd0);
        bus_write(A_EN, 32'h0);
        lines = IDLE;
        wait_cyc(4);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_write(A_POL, 32'hFFFF_FFFF);
        lines = 32'hFFFF_FFFF;
        wait_cyc(4);
        bus_read(A_SUM, d); check("R6 reserved read zero", d, 32'h800F_FFFF);
        bus_write(A_EN, 32'h7FF0_0000);
        wait_cyc(3);
        check("R6 reserved no irq", {31'd0, irq}, 32'd0);
        bus_write(A_EN, 32'h0);
        bus_write(A_POL, 32'h8000_0000);
        lines = IDLE;
        wait_cyc(4);
    endtask

    task automatic t_restart();
        @(negedge clk); addr = A_RST; wdata = 32'h0000_1234; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check("R8 wrong value", {31'd0, rreq}, 32'd0);
        @(negedge clk); addr = A_RST; wdata = 32'h0000_DEAD; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check("R8 key pulse", {31'd0, rreq}, 32'd1);
        @(negedge clk);
        check("R8 one cycle", {31'd0, rreq}, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_write(A_EN, 32'h0000_5A5A);
        bus_read(A_EN, d);    check("R9 enable readback", d, 32'h0000_5A5A);
        bus_write(A_EN, 32'h0);
        bus_write(A_CLR, 32'h0000_0001);
        bus_read(A_CLR, d);   check("R9 clear readback", d, 32'h1);
        bus_write(A_CLR, 32'h0);
        bus_read(5'h18, d);   check("R9 unmapped", d, 32'h0);
        bus_read(5'h06, d);   check("R9 misaligned", d, 32'h0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset_state();
        t_level_polarity();
        t_edge_clear();
        t_mask_irq();
        t_reserved();
        t_restart();
        t_map();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule